// File: doc/BRIEF.md
# Cascadable Serial-In Parallel-Out Display Driver

This block is the logic core of a column or row driver for a matrix display. A serial bit stream enters a shift chain one bit per rising clock edge. A load strobe copies the chain into a bank of holding registers. An output stage then shapes the held pattern into the channel levels. The shaping has four modes: it can blank every channel high, blank every channel low, show the pattern inverted, or show it as loaded.

The last stage of the chain is brought out as a serial output. Several drivers can therefore share one data stream, with each driver passing bits on to the next. A build parameter chooses which way the channel numbering runs along the chain, so the same core fits a driver laid out in either direction. The channel outputs are plain logic bits. Level shifting and analog drive belong to the pad ring.

Top module: `sipo_display_driver`

## Requirements
- R1: On every rising clock edge with `rst_n` high, stage 0 of the chain takes `ser_in` and every stage k takes the old value of stage k-1.
- R2: The inputs `load`, `unblank` and `pass_true` have no effect on the chain contents or on `ser_out`.
- R3: At a rising edge with `load` high, the holding registers take the chain contents as they stood before that edge. The output therefore shows them one cycle later than a transparent latch would.
- R4: At a rising edge with `load` low, the holding registers keep their value while the chain keeps shifting.
- R5: With `unblank`=0 and `pass_true`=0, every bit of `drive` is 1 whatever is held.
- R6: With `unblank`=0 and `pass_true`=1, every bit of `drive` is 0 whatever is held.
- R7: With `unblank`=1 and `pass_true`=0, each `drive` bit is the inverse of its held bit.
- R8: With `unblank`=1 and `pass_true`=1, each `drive` bit equals its held bit.
- R9: `ser_out` is the last chain stage. A bit sent to a driver comes out of `ser_out` CHANNELS edges later, so two chained drivers hold 2*CHANNELS bits.
- R10: With REVERSE=0, `drive[k]` comes from chain stage k, so the first stage feeds `drive[0]`. With REVERSE=1, `drive[k]` comes from stage CHANNELS-1-k.
- R11: A rising edge with `rst_n` low clears the chain and the holding registers. The mode logic still applies afterwards, so invert mode shows all ones and pass mode shows all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and load clock, rising edge |
| rst_n | input | 1 | Synchronous clear, active low |
| ser_in | input | 1 | Serial data into chain stage 0 |
| load | input | 1 | Copy the chain into the holding registers at the edge |
| unblank | input | 1 | 0 forces every channel to one level; 1 shows the held pattern |
| pass_true | input | 1 | Chooses the blank level (1 gives low) or the display sense (1 gives true) |
| ser_out | output | 1 | Last chain stage, for cascading |
| drive | output | CHANNELS | Channel levels |

## Verification
A load and a shift share the same clock edge whenever `load` is high. The holding registers must then capture the pre-shift chain, while the chain moves on by one place. The bench holds `load` high directly after a 64-bit burst through two chained drivers. It also asserts `load` at random while data streams in. On every clock it compares each channel against a queue model that copies before it shifts. Mode changes are made in the same cycles as loads, which confirms that the shaping reads only the held bits.

// File: rtl/sipo_display_driver.sv
module sipo_display_driver #(
  parameter int CHANNELS = 32,
  parameter bit REVERSE  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                load,
  input  logic                unblank,
  input  logic                pass_true,
  output logic                ser_out,
  output logic [CHANNELS-1:0] drive
);

  logic [CHANNELS-1:0] stages;
  logic [CHANNELS-1:0] held;
  logic [CHANNELS-1:0] mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) stages <= '0;
    else        stages <= {stages[CHANNELS-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= stages;
  end

  generate
    if (REVERSE) begin : g_rev
      for (genvar k = 0; k < CHANNELS; k++) begin : g_bit
        assign mapped[k] = held[CHANNELS-1-k];
      end
    end else begin : g_fwd
      assign mapped = held;
    end
  endgenerate

  assign ser_out = stages[CHANNELS-1];

  always_comb begin
    case ({unblank, pass_true})
      2'b00:   drive = '1;
      2'b01:   drive = '0;
      2'b10:   drive = ~mapped;
      default: drive = mapped;
    endcase
  end

endmodule

module sipo_display_driver_chk #(
  parameter int CHANNELS = 32,
  parameter bit REVERSE  = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ser_in,
  input logic                load,
  input logic                unblank,
  input logic                pass_true,
  input logic                ser_out,
  input logic [CHANNELS-1:0] drive,
  input logic [CHANNELS-1:0] stages,
  input logic [CHANNELS-1:0] held
);

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stages == {$past(stages[CHANNELS-2:0]), $past(ser_in)}));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load)) |-> (held == $past(stages)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load)) |-> $stable(held));

  p_blank_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unblank && !pass_true) |-> (&drive));

  p_blank_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!unblank && pass_true) |-> (drive == '0));

  p_cascade_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ser_out == $past(stages[CHANNELS-2])));

endmodule

bind sipo_display_driver sipo_display_driver_chk #(
  .CHANNELS(CHANNELS),
  .REVERSE (REVERSE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .load     (load),
  .unblank  (unblank),
  .pass_true(pass_true),
  .ser_out  (ser_out),
  .drive    (drive),
  .stages   (stages),
  .held     (held)
);

// File: tb/tb_sipo_display_driver.sv
`timescale 1ns/1ps
module tb_sipo_display_driver;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, load = 1'b0, unblank = 1'b1, pass_true = 1'b1;
  logic so_a, so_b, so_c;
  logic [N-1:0] dr_a, dr_b, dr_c;

  always #2.5 clk = ~clk;

  sipo_display_driver #(.CHANNELS(N), .REVERSE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .load(load), .unblank(unblank),
    .pass_true(pass_true), .ser_out(so_a), .drive(dr_a));
  sipo_display_driver #(.CHANNELS(N), .REVERSE(1'b0)) dut_next (
    .clk(clk), .rst_n(rst_n), .ser_in(so_a), .load(load), .unblank(unblank),
    .pass_true(pass_true), .ser_out(so_b), .drive(dr_b));
  sipo_display_driver #(.CHANNELS(N), .REVERSE(1'b1)) dut_rev (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .load(load), .unblank(unblank),
    .pass_true(pass_true), .ser_out(so_c), .drive(dr_c));

  int n_chk = 0, n_bad = 0;
  bit armed = 0, done = 0;

  bit hist[$];
  logic [N-1:0] m_la = '0, m_lb = '0;

  function automatic logic [N-1:0] dev_sr(int base);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = hist[base + k];
    return v;
  endfunction

  function automatic logic [N-1:0] flip(logic [N-1:0] v);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = v[N-1-k];
    return r;
  endfunction

  function automatic logic [N-1:0] shape(logic [N-1:0] v);
    if (!unblank) return pass_true ? '0 : '1;
    return pass_true ? v : ~v;
  endfunction

  function automatic string mode_tag();
    case ({unblank, pass_true})
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 2*N; i++) hist.push_back(1'b0);

  always @(posedge clk) begin
    armed <= 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < 2*N; i++) hist[i] = 1'b0;
      m_la = '0;
      m_lb = '0;
    end else begin
      if (load) begin
        m_la = dev_sr(0);
        m_lb = dev_sr(N);
      end
      hist.push_front(ser_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk({mode_tag(), " dev0"}, dr_a, shape(m_la));
      chk({mode_tag(), " dev1"}, dr_b, shape(m_lb));
      chk("R10 reversed", dr_c, shape(flip(m_la)));
      chk("R1 R2 R9 ser_out", {{(N-2){1'b0}}, so_b, so_a}, {{(N-2){1'b0}}, hist[2*N-1], hist[N-1]});
    end
  end

  task automatic step(logic d, logic ld);
    @(posedge clk);
    #1;
    ser_in = d;
    load = ld;
  endtask

  localparam logic [2*N-1:0] PAT = 64'hA5C3_0F96_3C5A_E718;

  initial begin
    logic [N-1:0] exp_a, exp_b;
    repeat (3) step(1'b1, 1'b1);
    @(negedge clk);
    chk("R11 reset pass mode", dr_a, '0);
    unblank = 1'b1; pass_true = 1'b0;
    #0.1;
    chk("R11 reset invert mode", dr_a, '1);
    @(posedge clk); #1;
    rst_n = 1'b1; unblank = 1'b1; pass_true = 1'b1;
    for (int i = 0; i < 2*N; i++) step(PAT[i], 1'b0);
    step(1'b0, 1'b1);
    @(negedge clk);
    chk("R9 cascade ser_out", {{(N-1){1'b0}}, so_b}, {{(N-1){1'b0}}, PAT[0]});
    chk("R4 no load yet", dr_a, '0);
    step(1'b0, 1'b0);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      exp_a[k] = PAT[2*N-1-k];
      exp_b[k] = PAT[N-1-k];
    end
    chk("R3 load dev0", dr_a, exp_a);
    chk("R3 R9 load dev1", dr_b, exp_b);
    chk("R10 reverse map", dr_c, PAT[2*N-1:N]);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    @(negedge clk);
    chk("R4 hold while shifting", dr_a, exp_a);
    unblank = 1'b1; pass_true = 1'b0; #0.1;
    chk("R7 invert", dr_b, ~exp_b);
    unblank = 1'b0; pass_true = 1'b0; #0.1;
    chk("R5 all high", dr_a, '1);
    unblank = 1'b0; pass_true = 1'b1; #0.1;
    chk("R6 all low", dr_b, '0);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      ser_in = 1'($urandom);
      load = (($urandom % 4) == 0);
      unblank = 1'($urandom);
      pass_true = 1'($urandom);
      rst_n = (($urandom % 300) != 0);
    end
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule